// File: doc/BRIEF.md
# Arbitrated True Dual-Port RAM

This block is a clocked model of a true dual-port static memory with an 18-bit word. A left port and a right port each carry their own address, write data, read data, read/write strobe, output enable, a pair of chip enables, two 9-bit lane enables and a sleep input. Either port can reach any word in any cycle. When both ports land on the same word and at least one of them writes, an arbiter names a winner and raises BUSY towards the loser, whose write is then dropped.

A strap input picks the role of the device when several copies are placed side by side to widen the word. A master drives BUSY from its own arbiter. A slave ignores its arbiter and takes BUSY from outside, so the master's decision blocks the slave's write. Sleep on a port shuts out all of that port's dynamic inputs. A depth parameter can halve the address space by ignoring the top address bit.

The arbiter is a three-state machine. The states are ARB_IDLE (no collision), ARB_LEFT (left port owns the contested word) and ARB_RIGHT (right port owns it). From ARB_IDLE a collision moves to ARB_RIGHT when the right port's access is continuing and the left port's access is new. Any other collision moves to ARB_LEFT. ARB_LEFT and ARB_RIGHT stay put while the collision lasts and return to ARB_IDLE in the first cycle without one. BUSY follows the state being entered, so it is valid in the same cycle as the collision.

Top module: `tdp_ram_arb`

## Requirements
- R1: A word is 18 bits wide. Active-low lane enable bit 0 guards bits 8:0 and bit 1 guards bits 17:9. A write changes only the lanes whose enable is 0.
- R2: A port is selected only when its chip enable 0 is low and its chip enable 1 is high. An unselected port writes nothing and reports no valid read data.
- R3: Both ports may read the same word in the same cycle. Both get it, and neither sees BUSY.
- R4: A collision is when both ports are selected at equal effective addresses and at least one writes. A write is read/write low with at least one lane enabled. When both accesses begin in the same cycle, the left port wins and the right BUSY output is 1.
- R5: An access begins when a port becomes selected or changes address. The port whose access began earlier wins. The winner keeps ownership while the collision lasts. BUSY is asserted in the same cycle as the collision.
- R6: In master mode (strap = 1) the losing port's write is suppressed and the BUSY inputs are ignored. In slave mode (strap = 0) a BUSY input of 1 suppresses that port's write, and both BUSY outputs are driven 0.
- R7: A read (selected, read/write high) puts the word, as it stood before that cycle's writes, on the data output at the next edge. The output-valid flag is 1 after the edge only if output enable was low. After reset the flag is 0.
- R8: While a port's sleep input is 1, that port does not write, its output-valid flag is 0 and its BUSY output is 0.
- R9: With HALF_DEPTH = 1 the top address bit is ignored, so two addresses that differ only in that bit reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms | input | 1 | Role strap: 1 master, 0 slave |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw_n | input | 1 | Left read/write, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_be_n | input | 2 | Left lane enables, active low |
| l_sleep | input | 1 | Left sleep |
| l_addr | input | ADDR_W | Left address |
| l_din | input | 18 | Left write data |
| l_dout | output | 18 | Left read data |
| l_dout_vld | output | 1 | Left read data valid (0 = high impedance) |
| l_busy_i | input | 1 | Left external BUSY (slave mode) |
| l_busy_o | output | 1 | Left BUSY (master mode) |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw_n | input | 1 | Right read/write, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_be_n | input | 2 | Right lane enables, active low |
| r_sleep | input | 1 | Right sleep |
| r_addr | input | ADDR_W | Right address |
| r_din | input | 18 | Right write data |
| r_dout | output | 18 | Right read data |
| r_dout_vld | output | 1 | Right read data valid |
| r_busy_i | input | 1 | Right external BUSY (slave mode) |
| r_busy_o | output | 1 | Right BUSY (master mode) |

## Verification
The same-word write check assumes master mode. In slave mode it relies on an outside master to hold BUSY, so it is gated by the strap, and the bench only issues same-word writes while the strap is 1. The properties take every input as settled at the sampling edge, because BUSY is combinational from the current inputs and the arbiter state. The bench changes inputs only on the falling edge, and it reads BUSY before the rising edge and read data just after it.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    localparam int WORD_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_LEFT  = 2'd1,
        ARB_RIGHT = 2'd2
    } arb_state_e;
endpackage

// File: rtl/tdp_port.sv
module tdp_port #(
    parameter int ADDR_W     = 10,
    parameter int HALF_DEPTH = 0,
    parameter int WORD_W     = tdp_pkg::WORD_W,
    parameter int LANE_W     = tdp_pkg::LANE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce0_n,
    input  logic                      ce1,
    input  logic                      rw_n,
    input  logic                      oe_n,
    input  logic [WORD_W/LANE_W-1:0]  be_n,
    input  logic                      sleep,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      block,
    output logic                      sel,
    output logic [ADDR_W-1:0]         eff_addr,
    output logic                      wr_req,
    output logic                      fresh,
    output logic [WORD_W/LANE_W-1:0]  wmask,
    output logic                      rd_en,
    output logic                      dout_vld
);
    localparam int LANES = WORD_W / LANE_W;
    localparam logic [ADDR_W-1:0] ADDR_KEEP =
        (HALF_DEPTH != 0) ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};

    logic [LANES-1:0]  lane_on;
    logic              prev_sel;
    logic [ADDR_W-1:0] prev_addr;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_on[g] = ~be_n[g];
        end
    endgenerate

    always_comb begin
        sel      = !sleep && !ce0_n && ce1;
        eff_addr = addr & ADDR_KEEP;
        wr_req   = sel && !rw_n && (|lane_on);
        wmask    = (wr_req && !block) ? lane_on : '0;
        rd_en    = sel && rw_n;
        fresh    = sel && !(prev_sel && (prev_addr == eff_addr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sel  <= 1'b0;
            prev_addr <= '0;
            dout_vld  <= 1'b0;
        end else begin
            prev_sel  <= sel;
            prev_addr <= eff_addr;
            dout_vld  <= rd_en && !oe_n;
        end
    end

    // R8: a sleeping port never reports valid data on the next cycle
    a_r8_sleep_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dout_vld);

    // R7: a selected read with output enable gives valid data next cycle
    a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ce0_n && ce1 && rw_n && !oe_n) |=> dout_vld);

    // R2: a deselected port never yields valid data
    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || !ce1) |=> !dout_vld);
endmodule

// File: rtl/tdp_arbiter.sv
module tdp_arbiter #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_l,
    input  logic              sel_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              wr_l,
    input  logic              wr_r,
    input  logic              fresh_l,
    input  logic              fresh_r,
    output logic              busy_l,
    output logic              busy_r
);
    import tdp_pkg::*;

    arb_state_e state, nxt;
    logic       coll;

    assign coll = sel_l && sel_r && (addr_l == addr_r) && (wr_l || wr_r);

    always_comb begin
        nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (coll) begin
                    if (fresh_l && !fresh_r) nxt = ARB_RIGHT;
                    else                     nxt = ARB_LEFT;
                end
            end
            ARB_LEFT, ARB_RIGHT: begin
                if (!coll) nxt = ARB_IDLE;
            end
            default: nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        busy_l = coll && (nxt == ARB_RIGHT);
        busy_r = coll && (nxt == ARB_LEFT);
    end

    // R4: at most one port loses a collision
    a_r4_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l && busy_r));

    // R5: the owner keeps the word; a loser never becomes the winner next cycle
    a_r5_left_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        busy_r |=> !busy_l);
    a_r5_right_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        busy_l |=> !busy_r);
endmodule

// File: rtl/tdp_array.sv
module tdp_array #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = tdp_pkg::WORD_W,
    parameter int LANE_W = tdp_pkg::LANE_W
) (
    input  logic                     clk,
    input  logic [ADDR_W-1:0]        addr_l,
    input  logic [WORD_W-1:0]        din_l,
    input  logic [WORD_W/LANE_W-1:0] wmask_l,
    input  logic                     rd_l,
    input  logic [ADDR_W-1:0]        addr_r,
    input  logic [WORD_W-1:0]        din_r,
    input  logic [WORD_W/LANE_W-1:0] wmask_r,
    input  logic                     rd_r,
    output logic [WORD_W-1:0]        q_l,
    output logic [WORD_W-1:0]        q_r
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rd_l) q_l <= mem[addr_l];
        if (rd_r) q_r <= mem[addr_r];
        for (int k = 0; k < LANES; k++) begin
            if (wmask_l[k]) mem[addr_l][k*LANE_W +: LANE_W] <= din_l[k*LANE_W +: LANE_W];
            if (wmask_r[k]) mem[addr_r][k*LANE_W +: LANE_W] <= din_r[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/tdp_ram_arb.sv
module tdp_ram_arb #(
    parameter int ADDR_W     = 10,
    parameter int HALF_DEPTH = 0,
    parameter int WORD_W     = tdp_pkg::WORD_W,
    parameter int LANE_W     = tdp_pkg::LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ms,
    input  logic                     l_ce0_n,
    input  logic                     l_ce1,
    input  logic                     l_rw_n,
    input  logic                     l_oe_n,
    input  logic [WORD_W/LANE_W-1:0] l_be_n,
    input  logic                     l_sleep,
    input  logic [ADDR_W-1:0]        l_addr,
    input  logic [WORD_W-1:0]        l_din,
    output logic [WORD_W-1:0]        l_dout,
    output logic                     l_dout_vld,
    input  logic                     l_busy_i,
    output logic                     l_busy_o,
    input  logic                     r_ce0_n,
    input  logic                     r_ce1,
    input  logic                     r_rw_n,
    input  logic                     r_oe_n,
    input  logic [WORD_W/LANE_W-1:0] r_be_n,
    input  logic                     r_sleep,
    input  logic [ADDR_W-1:0]        r_addr,
    input  logic [WORD_W-1:0]        r_din,
    output logic [WORD_W-1:0]        r_dout,
    output logic                     r_dout_vld,
    input  logic                     r_busy_i,
    output logic                     r_busy_o
);
    localparam int LANES = WORD_W / LANE_W;

    logic              l_sel, r_sel, l_wr, r_wr, l_fresh, r_fresh;
    logic              l_rd, r_rd, l_arb_busy, r_arb_busy, l_blk, r_blk;
    logic [ADDR_W-1:0] l_ea, r_ea;
    logic [LANES-1:0]  l_wm, r_wm;

    always_comb begin
        l_blk    = ms ? l_arb_busy : l_busy_i;
        r_blk    = ms ? r_arb_busy : r_busy_i;
        l_busy_o = ms && l_arb_busy;
        r_busy_o = ms && r_arb_busy;
    end

    tdp_port #(.ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_lport (
        .clk(clk), .rst_n(rst_n), .ce0_n(l_ce0_n), .ce1(l_ce1), .rw_n(l_rw_n),
        .oe_n(l_oe_n), .be_n(l_be_n), .sleep(l_sleep), .addr(l_addr), .block(l_blk),
        .sel(l_sel), .eff_addr(l_ea), .wr_req(l_wr), .fresh(l_fresh), .wmask(l_wm),
        .rd_en(l_rd), .dout_vld(l_dout_vld));

    tdp_port #(.ADDR_W(ADDR_W), .HALF_DEPTH(HALF_DEPTH), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_rport (
        .clk(clk), .rst_n(rst_n), .ce0_n(r_ce0_n), .ce1(r_ce1), .rw_n(r_rw_n),
        .oe_n(r_oe_n), .be_n(r_be_n), .sleep(r_sleep), .addr(r_addr), .block(r_blk),
        .sel(r_sel), .eff_addr(r_ea), .wr_req(r_wr), .fresh(r_fresh), .wmask(r_wm),
        .rd_en(r_rd), .dout_vld(r_dout_vld));

    tdp_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .sel_l(l_sel), .sel_r(r_sel),
        .addr_l(l_ea), .addr_r(r_ea), .wr_l(l_wr), .wr_r(r_wr),
        .fresh_l(l_fresh), .fresh_r(r_fresh), .busy_l(l_arb_busy), .busy_r(r_arb_busy));

    tdp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .addr_l(l_ea), .din_l(l_din), .wmask_l(l_wm), .rd_l(l_rd),
        .addr_r(r_ea), .din_r(r_din), .wmask_r(r_wm), .rd_r(r_rd),
        .q_l(l_dout), .q_r(r_dout));

    // R6: a blocked port never writes
    a_r6_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        l_blk |-> (l_wm == '0));
    a_r6_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        r_blk |-> (r_wm == '0));

    // R4: in master mode the two ports never write the same word in one cycle
    a_r4_no_shared_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ms && (|l_wm) && (|r_wm)) |-> (l_ea != r_ea));

    // R8: a sleeping port never reports BUSY
    a_r8_sleep_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sleep |-> !l_busy_o) and (r_sleep |-> !r_busy_o));
endmodule

// File: tb/tdp_ram_arb_tb.sv
module tdp_ram_arb_tb;
    localparam int AW = 10;

    typedef struct packed {
        logic [1:0]  lop;  logic [9:0] la; logic [17:0] ld; logic [1:0] lb;
        logic [1:0]  rop;  logic [9:0] ra; logic [17:0] rd; logic [1:0] rb;
        logic        ebl;  logic ebr;
    } vec_t;

    // op: 0 deselected, 1 read, 2 write
    localparam vec_t VECS [13] = '{
        '{2'd2, 10'd5, 18'h0ABCD, 2'b00, 2'd0, 10'd0, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd0, 10'd0, 18'h0,     2'b11, 2'd2, 10'd6, 18'h12345, 2'b00, 1'b0, 1'b0},
        '{2'd1, 10'd5, 18'h0,     2'b11, 2'd1, 10'd6, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd1, 10'd5, 18'h0,     2'b11, 2'd1, 10'd5, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd2, 10'd7, 18'h00C0C, 2'b00, 2'd2, 10'd7, 18'h00D0D, 2'b00, 1'b0, 1'b1},
        '{2'd0, 10'd0, 18'h0,     2'b11, 2'd1, 10'd7, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd1, 10'd7, 18'h0,     2'b11, 2'd2, 10'd7, 18'h00E0E, 2'b00, 1'b1, 1'b0},
        '{2'd1, 10'd7, 18'h0,     2'b11, 2'd2, 10'd7, 18'h00F0F, 2'b00, 1'b1, 1'b0},
        '{2'd2, 10'd7, 18'h01111, 2'b00, 2'd2, 10'd7, 18'h02222, 2'b00, 1'b1, 1'b0},
        '{2'd0, 10'd0, 18'h0,     2'b11, 2'd0, 10'd0, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd1, 10'd7, 18'h0,     2'b11, 2'd2, 10'd8, 18'h15555, 2'b00, 1'b0, 1'b0},
        '{2'd2, 10'd8, 18'h2AAAA, 2'b01, 2'd0, 10'd0, 18'h0,     2'b11, 1'b0, 1'b0},
        '{2'd1, 10'd7, 18'h0,     2'b11, 2'd1, 10'd8, 18'h0,     2'b11, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, ms = 1'b1;
    logic l_ce0_n, l_ce1, l_rw_n, l_oe_n, l_sleep, l_busy_i, l_dout_vld, l_busy_o;
    logic r_ce0_n, r_ce1, r_rw_n, r_oe_n, r_sleep, r_busy_i, r_dout_vld, r_busy_o;
    logic [1:0]  l_be_n, r_be_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [17:0] l_din, r_din, l_dout, r_dout, h_dout;
    logic        h_vld, h_busy;
    logic [17:0] h_rdout;
    logic        h_rvld, h_rbusy;

    logic [17:0] model [1 << AW];
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    tdp_ram_arb #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms(ms),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_be_n(l_be_n),
        .l_sleep(l_sleep), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
        .l_dout_vld(l_dout_vld), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
        .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_be_n(r_be_n),
        .r_sleep(r_sleep), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout),
        .r_dout_vld(r_dout_vld), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o));

    tdp_ram_arb #(.ADDR_W(AW), .HALF_DEPTH(1)) u_half (
        .clk(clk), .rst_n(rst_n), .ms(1'b1),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_be_n(l_be_n),
        .l_sleep(l_sleep), .l_addr(l_addr), .l_din(l_din), .l_dout(h_dout),
        .l_dout_vld(h_vld), .l_busy_i(1'b0), .l_busy_o(h_busy),
        .r_ce0_n(1'b1), .r_ce1(1'b0), .r_rw_n(1'b1), .r_oe_n(1'b1), .r_be_n(2'b11),
        .r_sleep(1'b0), .r_addr('0), .r_din('0), .r_dout(h_rdout),
        .r_dout_vld(h_rvld), .r_busy_i(1'b0), .r_busy_o(h_rbusy));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_l(input int op, input logic [AW-1:0] a, input logic [17:0] d,
                         input logic [1:0] be, input logic oe);
        l_ce0_n = 1'b0; l_ce1 = (op != 0); l_rw_n = (op != 2);
        l_addr = a; l_din = d; l_be_n = be; l_oe_n = oe;
    endtask

    task automatic set_r(input int op, input logic [AW-1:0] a, input logic [17:0] d,
                         input logic [1:0] be, input logic oe);
        r_ce0_n = 1'b0; r_ce1 = (op != 0); r_rw_n = (op != 2);
        r_addr = a; r_din = d; r_be_n = be; r_oe_n = oe;
    endtask

    task automatic mwrite(input logic [AW-1:0] a, input logic [17:0] d, input logic [1:0] be);
        for (int k = 0; k < 2; k++)
            if (!be[k]) model[a][k*9 +: 9] = d[k*9 +: 9];
    endtask

    task automatic edge_wait();
        @(posedge clk); #1;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [17:0] el, er;
        l_sleep = 1'b0; r_sleep = 1'b0; l_busy_i = 1'b0; r_busy_i = 1'b0;
        set_l(0, '0, '0, 2'b11, 1'b1);
        set_r(0, '0, '0, 2'b11, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset left valid", l_dout_vld, 0);
        check("R7 reset right valid", r_dout_vld, 0);
        check("R4 reset busy", {l_busy_o, r_busy_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // table walk
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            set_l(VECS[i].lop, VECS[i].la, VECS[i].ld, VECS[i].lb, 1'b0);
            set_r(VECS[i].rop, VECS[i].ra, VECS[i].rd, VECS[i].rb, 1'b0);
            el = model[VECS[i].la];
            er = model[VECS[i].ra];
            #1;
            check($sformatf("R4/R5 vec%0d left busy", i), l_busy_o, VECS[i].ebl);
            check($sformatf("R4/R5 vec%0d right busy", i), r_busy_o, VECS[i].ebr);
            edge_wait();
            check($sformatf("R7 vec%0d left valid", i), l_dout_vld, VECS[i].lop == 1);
            check($sformatf("R7 vec%0d right valid", i), r_dout_vld, VECS[i].rop == 1);
            if (VECS[i].lop == 1) check($sformatf("R1/R3 vec%0d left data", i), l_dout, el);
            if (VECS[i].rop == 1) check($sformatf("R1/R3 vec%0d right data", i), r_dout, er);
            if (VECS[i].lop == 2 && !VECS[i].ebl) mwrite(VECS[i].la, VECS[i].ld, VECS[i].lb);
            if (VECS[i].rop == 2 && !VECS[i].ebr) mwrite(VECS[i].ra, VECS[i].rd, VECS[i].rb);
        end
        check("R1 merged lanes", model[8], 18'h2AB55);

        // R2: chip enable 0 high blocks write and read
        @(negedge clk);
        set_r(0, '0, '0, 2'b11, 1'b1);
        set_l(2, 10'd5, 18'h3FFFF, 2'b00, 1'b0); l_ce0_n = 1'b1;
        edge_wait();
        @(negedge clk); set_l(1, 10'd5, '0, 2'b11, 1'b0); l_ce0_n = 1'b1;
        edge_wait();
        check("R2 deselected read valid", l_dout_vld, 0);
        @(negedge clk); set_l(1, 10'd5, '0, 2'b11, 1'b0);
        edge_wait();
        check("R2 deselected write ignored", l_dout, model[5]);

        // R7: output enable high hides data
        @(negedge clk); set_l(1, 10'd5, '0, 2'b11, 1'b1);
        edge_wait();
        check("R7 oe high valid", l_dout_vld, 0);

        // R8: sleep blocks write and output
        @(negedge clk); l_sleep = 1'b1; set_l(2, 10'd5, 18'h00000, 2'b00, 1'b0);
        edge_wait();
        @(negedge clk); set_l(1, 10'd5, '0, 2'b11, 1'b0);
        edge_wait();
        check("R8 sleep valid", l_dout_vld, 0);
        @(negedge clk); l_sleep = 1'b0;
        edge_wait();
        check("R8 sleep write ignored", l_dout, model[5]);

        // R8: sleep clears a lost collision
        @(negedge clk); set_l(0, '0, '0, 2'b11, 1'b1); set_r(2, 10'd20, 18'h00020, 2'b00, 1'b1);
        edge_wait(); mwrite(10'd20, 18'h00020, 2'b00);
        @(negedge clk); set_l(1, 10'd20, '0, 2'b11, 1'b0); set_r(2, 10'd20, 18'h00021, 2'b00, 1'b1);
        #1;
        check("R5 later reader loses", l_busy_o, 1);
        edge_wait(); mwrite(10'd20, 18'h00021, 2'b00);
        @(negedge clk); l_sleep = 1'b1;
        #1;
        check("R8 sleep clears busy", {l_busy_o, r_busy_o}, 0);
        edge_wait();
        @(negedge clk); l_sleep = 1'b0; set_l(0, '0, '0, 2'b11, 1'b1); set_r(0, '0, '0, 2'b11, 1'b1);
        edge_wait();

        // R6: slave mode external busy blocks writes
        @(negedge clk); ms = 1'b0; set_l(2, 10'd30, 18'h11130, 2'b00, 1'b1);
        edge_wait();
        @(negedge clk); l_busy_i = 1'b1; set_l(2, 10'd30, 18'h22230, 2'b00, 1'b1);
        #1;
        check("R6 slave busy output low", l_busy_o, 0);
        edge_wait();
        @(negedge clk); l_busy_i = 1'b0; set_l(1, 10'd30, '0, 2'b11, 1'b0);
        edge_wait();
        check("R6 slave blocked write", l_dout, 18'h11130);
        // R6: master ignores external busy
        @(negedge clk); ms = 1'b1; l_busy_i = 1'b1; set_l(2, 10'd31, 18'h33331, 2'b00, 1'b1);
        edge_wait();
        @(negedge clk); l_busy_i = 1'b0; set_l(1, 10'd31, '0, 2'b11, 1'b0);
        edge_wait();
        check("R6 master ignores busy input", l_dout, 18'h33331);

        // R9: half depth aliases the top address bit
        @(negedge clk); set_l(2, 10'h205, 18'h05205, 2'b00, 1'b1);
        edge_wait(); mwrite(10'h205, 18'h05205, 2'b00);
        @(negedge clk); set_l(1, 10'h005, '0, 2'b11, 1'b0);
        edge_wait();
        check("R9 half depth alias", h_dout, 18'h05205);
        check("R9 full depth no alias", l_dout, model[5]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule